// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Front End

This block sits between a two-wire serial bus and the storage array of a serial memory. Both bus lines pass through synchronizers into the system clock domain. The block then finds the start and stop conditions on the bus and shifts in the device address byte. It answers the bus master by pulling SDA low through an open-drain enable. The three strap inputs select which of eight positions on a shared bus the target answers to.

On the storage side the block works at byte level. It reports start and stop events as single-cycle pulses. When the address matches it reports the transfer direction, and in the write direction it hands over each received byte. In the read direction it takes the byte to transmit from the storage side and signals each load. After every transmitted byte it reports whether the master acknowledged. The storage side raises `busy_i` while its self-timed write is in progress. During that time the target does not answer its own address, so a master can poll the target with repeated addressing attempts.

Top module: `twi_target`

## Requirements
- R1: A fall of SDA while SCL is high is a start condition and gives a one-cycle `start_o` pulse. A rise of SDA while SCL is high is a stop condition and gives a one-cycle `stop_o` pulse.
- R2: Bits are taken on SCL rising edges, most significant bit first. A complete byte in the write direction appears on `rx_byte_o`, together with a one-cycle `rx_valid_o` pulse.
- R3: The address byte matches when bits 7..4 are 1010 and bits 3..1 equal `strap_i[2:0]`. On a match the target pulses `addr_hit_o` and pulls SDA low for the whole ninth clock. `rd_o` then takes bit 0 of the address byte (1 = read, 0 = write).
- R4: On an address mismatch the target does not acknowledge. It then ignores the bus, giving no acknowledge and no received byte, until the next start.
- R5: Bits clocked on the bus before any start condition are ignored.
- R6: In the write direction, every data byte after the address is acknowledged with a low SDA during its ninth clock.
- R7: If `busy_i` is high when the address byte completes, the target does not acknowledge. The same addressing attempt made after `busy_i` falls is acknowledged.
- R8: In the read direction the target sends `tx_byte_i` MSB first and pulses `tx_load_o` once per byte it loads. The SDA enable never rises while SCL is high.
- R9: After each transmitted byte the target samples the master's ninth bit. It reports the result on `mack_o` (1 = master drove low) with a `mack_valid_o` pulse. It sends another byte only when `mack_o` is 1. Otherwise it releases SDA and waits for a stop.
- R10: A start that arrives with no stop before it restarts address reception.
- R11: SDA is released except during an acknowledge or a transmitted data bit. A stop returns the target to standby, where bits are ignored until the next start.
- R12: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Board-level address select straps |
| busy_i | input | 1 | Storage side is in its self-timed write |
| tx_byte_i | input | 8 | Byte to transmit in the read direction |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| start_o | output | 1 | Start condition seen (pulse) |
| stop_o | output | 1 | Stop condition seen (pulse) |
| addr_hit_o | output | 1 | Own address accepted (pulse) |
| rd_o | output | 1 | Direction of the current transfer, 1 = read |
| rx_valid_o | output | 1 | Write-direction data byte received (pulse) |
| rx_byte_o | output | 8 | Last received data byte |
| tx_load_o | output | 1 | `tx_byte_i` was taken for transmission (pulse) |
| mack_valid_o | output | 1 | Master's acknowledge bit sampled (pulse) |
| mack_o | output | 1 | 1 when the master acknowledged the last byte |

## Verification
A bit counter that is off by one, or a state that is lost, moves the open-drain enable into the wrong SCL period. The bench compares the enable on every clock of every SCL high phase against a behavioural model of the bus, so such a fault shows at the port within the SCL period where it happens. A wrong address decision or a wrong busy decision shows at the ninth clock of that byte, as an acknowledge that should or should not be there. A wrong byte path or a wrong acknowledge path shows on the byte handshake when the transaction ends: in the received-byte queue, in the count of load pulses, or in the sequence of master acknowledges.

// File: rtl/twi_target_pkg.sv
package twi_target_pkg;

    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 3;
    localparam int CODE_W  = 4;
    localparam int CNT_W   = $clog2(BYTE_W) + 1;

    localparam logic [CODE_W-1:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_WAIT_STOP
    } tgt_state_t;

    // One synchronized bus line with its edge information.
    typedef struct packed {
        logic level;
        logic prev;
        logic rise;
        logic fall;
    } line_t;

    function automatic logic addr_match(input logic [BYTE_W-1:0] b,
                                        input logic [STRAP_W-1:0] s);
        return (b[BYTE_W-1 -: CODE_W] == DEV_CODE) &&
               (b[BYTE_W-1-CODE_W -: STRAP_W] == s);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_target_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output line_t ln
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // The idle bus level is high, so reset to ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    always_comb begin
        ln.level = chain[STAGES-1];
        ln.prev  = prev;
        ln.rise  = chain[STAGES-1] & ~prev;
        ln.fall  = ~chain[STAGES-1] & prev;
    end

endmodule

// File: rtl/twi_target_fsm.sv
module twi_target_fsm
    import twi_target_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  line_t              scl,
    input  line_t              sda,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic [BYTE_W-1:0]  tx_byte_i,
    output logic               sda_oe_o,
    output logic               start_o,
    output logic               stop_o,
    output logic               addr_hit_o,
    output logic               rd_o,
    output logic               rx_valid_o,
    output logic [BYTE_W-1:0]  rx_byte_o,
    output logic               tx_load_o,
    output logic               mack_valid_o,
    output logic               mack_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    tgt_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr;
    logic              start_c;
    logic              stop_c;

    // A change of SDA while SCL stays high is always a bus condition.
    assign start_c = scl.level & scl.prev & sda.fall;
    assign stop_c  = scl.level & scl.prev & sda.rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            sr           <= '0;
            sda_oe_o     <= 1'b0;
            start_o      <= 1'b0;
            stop_o       <= 1'b0;
            addr_hit_o   <= 1'b0;
            rd_o         <= 1'b0;
            rx_valid_o   <= 1'b0;
            rx_byte_o    <= '0;
            tx_load_o    <= 1'b0;
            mack_valid_o <= 1'b0;
            mack_o       <= 1'b0;
        end else begin
            start_o      <= 1'b0;
            stop_o       <= 1'b0;
            addr_hit_o   <= 1'b0;
            rx_valid_o   <= 1'b0;
            tx_load_o    <= 1'b0;
            mack_valid_o <= 1'b0;
            if (start_c) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                sda_oe_o <= 1'b0;
                start_o  <= 1'b1;
            end else if (stop_c) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
                stop_o   <= 1'b1;
            end else begin
                case (state)
                    ST_ADDR, ST_WR_DATA: begin
                        if (scl.rise && cnt != FULL) begin
                            sr  <= {sr[BYTE_W-2:0], sda.level};
                            cnt <= cnt + 1'b1;
                        end else if (scl.fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_match(sr, strap_i) && !busy_i) begin
                                    state      <= ST_ADDR_ACK;
                                    sda_oe_o   <= 1'b1;
                                    rd_o       <= sr[0];
                                    addr_hit_o <= 1'b1;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                state      <= ST_WR_ACK;
                                sda_oe_o   <= 1'b1;
                                rx_valid_o <= 1'b1;
                                rx_byte_o  <= sr;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl.fall) begin
                            if (rd_o) begin
                                state     <= ST_RD_DATA;
                                sr        <= tx_byte_i;
                                sda_oe_o  <= ~tx_byte_i[BYTE_W-1];
                                tx_load_o <= 1'b1;
                                cnt       <= '0;
                            end else begin
                                state    <= ST_WR_DATA;
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl.fall) begin
                            state    <= ST_WR_DATA;
                            sda_oe_o <= 1'b0;
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl.fall) begin
                            if (cnt == LAST) begin
                                state    <= ST_RD_ACK;
                                sda_oe_o <= 1'b0;
                                cnt      <= '0;
                            end else begin
                                cnt      <= cnt + 1'b1;
                                sr       <= {sr[BYTE_W-2:0], 1'b0};
                                sda_oe_o <= ~sr[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl.rise) begin
                            mack_o       <= ~sda.level;
                            mack_valid_o <= 1'b1;
                        end else if (scl.fall) begin
                            if (mack_o) begin
                                state     <= ST_RD_DATA;
                                sr        <= tx_byte_i;
                                sda_oe_o  <= ~tx_byte_i[BYTE_W-1];
                                tx_load_o <= 1'b1;
                                cnt       <= '0;
                            end else begin
                                state <= ST_WAIT_STOP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/twi_target.sv
module twi_target
    import twi_target_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic [BYTE_W-1:0]  tx_byte_i,
    output logic               sda_oe_o,
    output logic               start_o,
    output logic               stop_o,
    output logic               addr_hit_o,
    output logic               rd_o,
    output logic               rx_valid_o,
    output logic [BYTE_W-1:0]  rx_byte_o,
    output logic               tx_load_o,
    output logic               mack_valid_o,
    output logic               mack_o
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    line_t              ln_q [N_LINES];
    line_t              scl_ln;
    line_t              sda_ln;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_lines[g]),
            .ln  (ln_q[g])
        );
    end

    assign scl_ln = ln_q[0];
    assign sda_ln = ln_q[1];

    twi_target_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .scl          (scl_ln),
        .sda          (sda_ln),
        .strap_i      (strap_i),
        .busy_i       (busy_i),
        .tx_byte_i    (tx_byte_i),
        .sda_oe_o     (sda_oe_o),
        .start_o      (start_o),
        .stop_o       (stop_o),
        .addr_hit_o   (addr_hit_o),
        .rd_o         (rd_o),
        .rx_valid_o   (rx_valid_o),
        .rx_byte_o    (rx_byte_o),
        .tx_load_o    (tx_load_o),
        .mack_valid_o (mack_valid_o),
        .mack_o       (mack_o)
    );

endmodule

// File: rtl/twi_target_chk.sv
module twi_target_chk (
    input logic clk,
    input logic rst,
    input logic scl_lvl,
    input logic scl_prv,
    input logic busy_i,
    input logic sda_oe_o,
    input logic start_o,
    input logic stop_o,
    input logic addr_hit_o,
    input logic rd_o,
    input logic rx_valid_o,
    input logic tx_load_o,
    input logic mack_valid_o
);

    // R1
    cond_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_o && stop_o));

    // R3
    hit_drives_ack_chk: assert property (@(posedge clk) disable iff (rst)
        addr_hit_o |-> sda_oe_o);

    // R7
    busy_blocks_hit_chk: assert property (@(posedge clk) disable iff (rst)
        addr_hit_o |-> !$past(busy_i));

    // R8
    no_drive_in_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && scl_prv) |=> !$rose(sda_oe_o));

    // R11
    stop_releases_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> !sda_oe_o);

    // R6
    rx_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> !rd_o);

    // R9
    handshake_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid_o, tx_load_o, mack_valid_o}));

endmodule

bind twi_target twi_target_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_lvl      (scl_ln.level),
    .scl_prv      (scl_ln.prev),
    .busy_i       (busy_i),
    .sda_oe_o     (sda_oe_o),
    .start_o      (start_o),
    .stop_o       (stop_o),
    .addr_hit_o   (addr_hit_o),
    .rd_o         (rd_o),
    .rx_valid_o   (rx_valid_o),
    .tx_load_o    (tx_load_o),
    .mack_valid_o (mack_valid_o)
);

// File: tb/twi_target_tb_top.sv
module twi_target_tb_top;

    localparam logic [2:0] STRAP = 3'b101;
    localparam int HALF = 16;
    localparam logic [7:0] ADDR_WR = 8'hAA;  // 1010_101_0
    localparam logic [7:0] ADDR_RD = 8'hAB;  // 1010_101_1

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy  = 1'b0;
    logic [7:0] tx_byte;
    logic       sda_oe, start_p, stop_p, hit, rd, rx_v, tx_load, mv, mack;
    logic [7:0] rx_b;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    twi_target dut_i (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .strap_i      (STRAP),
        .busy_i       (busy),
        .tx_byte_i    (tx_byte),
        .sda_oe_o     (sda_oe),
        .start_o      (start_p),
        .stop_o       (stop_p),
        .addr_hit_o   (hit),
        .rd_o         (rd),
        .rx_valid_o   (rx_v),
        .rx_byte_o    (rx_b),
        .tx_load_o    (tx_load),
        .mack_valid_o (mv),
        .mack_o       (mack)
    );

    int checks = 0;
    int errors = 0;
    int n_start = 0, n_stop = 0, n_hit = 0, n_load = 0;
    logic [7:0] rxq[$];
    logic       mackq[$];
    logic [7:0] mem [8];
    int         rd_ptr = 0;
    logic       exp_oe = 1'b0;
    bit         mon_en = 1'b0;
    int         hi_cnt = 0;
    bit         done = 1'b0;

    assign tx_byte = mem[rd_ptr % 8];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Storage-side model and event capture.
    always @(posedge clk) begin
        if (!rst) begin
            if (tx_load) rd_ptr <= rd_ptr + 1;
            if (start_p) n_start++;
            if (stop_p)  n_stop++;
            if (hit)     n_hit++;
            if (tx_load) n_load++;
            if (rx_v)    rxq.push_back(rx_b);
            if (mv)      mackq.push_back(mack);
        end
    end

    // Per-clock comparison of the drive enable against the bus model.
    always @(negedge clk) begin
        if (scl_m) hi_cnt++;
        else hi_cnt = 0;
        if (mon_en && hi_cnt >= 4)
            chk(sda_oe === exp_oe, "R8/R11 drive during SCL high", 32'(sda_oe), 32'(exp_oe));
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b, input logic e_oe, output logic seen);
        sda_m = b;
        wclk(HALF / 2);
        exp_oe = e_oe;
        scl_m = 1'b1;
        wclk(HALF / 2);
        seen = sda_bus;
        wclk(HALF / 2);
        scl_m = 1'b0;
        wclk(HALF / 2);
    endtask

    task automatic do_start();
        if (!scl_m) begin
            sda_m = 1'b1;
            wclk(HALF / 2);
            exp_oe = 1'b0;
            scl_m = 1'b1;
            wclk(HALF / 2);
        end else begin
            sda_m = 1'b1;
            exp_oe = 1'b0;
            wclk(HALF / 2);
        end
        sda_m = 1'b0;
        wclk(HALF);
        scl_m = 1'b0;
        wclk(HALF / 2);
    endtask

    task automatic do_stop();
        sda_m = 1'b0;
        wclk(HALF / 2);
        exp_oe = 1'b0;
        scl_m = 1'b1;
        wclk(HALF);
        sda_m = 1'b1;
        wclk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        logic seen;
        for (int i = 7; i >= 0; i--) put_bit(b[i], 1'b0, seen);
        put_bit(1'b1, exp_ack, seen);
        chk(seen == ~exp_ack, req, 32'(seen), 32'(~exp_ack));
    endtask

    task automatic recv_byte(input logic [7:0] expb, input logic m_ack, input string req);
        logic       seen;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, ~expb[i], seen);
            got[i] = seen;
        end
        chk(got == expb, req, 32'(got), 32'(expb));
        put_bit(~m_ack, 1'b0, seen);
    endtask

    initial begin
        int s0, p0, h0, l0, q0, pp;
        mem[0] = 8'hA5; mem[1] = 8'h0F; mem[2] = 8'hF0; mem[3] = 8'h81;
        mem[4] = 8'h7E; mem[5] = 8'h3C; mem[6] = 8'hC3; mem[7] = 8'h5A;
        wclk(10);
        rst = 1'b0;
        wclk(2);
        // R12: reset state
        chk({sda_oe, start_p, stop_p, hit, rd, rx_v, tx_load, mv, mack} == '0,
            "R12 outputs after reset",
            32'({sda_oe, start_p, stop_p, hit, rd, rx_v, tx_load, mv, mack}), 0);
        chk(rx_b == 8'h00, "R12 rx_byte after reset", 32'(rx_b), 0);
        mon_en = 1'b1;

        // R5: a matching address clocked without a start is ignored
        scl_m = 1'b0;
        wclk(HALF);
        send_byte(ADDR_WR, 1'b0, "R5 no ack before start");
        send_byte(8'h11, 1'b0, "R5 no ack for data before start");
        chk(n_hit == 0 && rxq.size() == 0, "R5 no hit or byte", 32'(n_hit + rxq.size()), 0);

        // Write transaction: R1, R2, R3, R6
        s0 = n_start; p0 = n_stop;
        do_start();
        chk(n_start == s0 + 1, "R1 start pulse", 32'(n_start - s0), 1);
        send_byte(ADDR_WR, 1'b1, "R3 address ack");
        chk(rd == 1'b0 && n_hit == 1, "R3 write direction and hit", 32'({rd, n_hit[3:0]}), 32'h1);
        send_byte(8'h3C, 1'b1, "R6 data ack 0");
        send_byte(8'hC3, 1'b1, "R6 data ack 1");
        send_byte(8'h00, 1'b1, "R6 data ack 2");
        do_stop();
        chk(n_stop == p0 + 1, "R1 stop pulse", 32'(n_stop - p0), 1);
        chk(rxq.size() == 3, "R2 byte count", 32'(rxq.size()), 3);
        if (rxq.size() == 3) begin
            chk(rxq[0] == 8'h3C, "R2 byte 0", 32'(rxq[0]), 32'h3C);
            chk(rxq[1] == 8'hC3, "R2 byte 1", 32'(rxq[1]), 32'hC3);
            chk(rxq[2] == 8'h00, "R2 byte 2", 32'(rxq[2]), 32'h00);
        end

        // R4: wrong strap bits, then wrong device code
        q0 = rxq.size(); h0 = n_hit;
        do_start();
        send_byte(8'hA6, 1'b0, "R4 strap mismatch nack");
        send_byte(8'h55, 1'b0, "R4 ignored after mismatch");
        do_stop();
        do_start();
        send_byte(8'hBA, 1'b0, "R4 code mismatch nack");
        send_byte(8'h66, 1'b0, "R4 ignored after code mismatch");
        do_stop();
        chk(rxq.size() == q0 && n_hit == h0, "R4 nothing accepted",
            32'(rxq.size() - q0 + n_hit - h0), 0);

        // R7: busy blocks the address, the same attempt succeeds afterwards
        busy = 1'b1;
        do_start();
        send_byte(ADDR_WR, 1'b0, "R7 busy nack");
        do_stop();
        busy = 1'b0;
        do_start();
        send_byte(ADDR_WR, 1'b1, "R7 ack after busy");
        send_byte(8'h99, 1'b1, "R6 data ack after poll");
        do_stop();
        chk(rxq.size() == q0 + 1 && rxq[rxq.size()-1] == 8'h99, "R7 byte after poll",
            32'(rxq[rxq.size()-1]), 32'h99);

        // R11: after a stop, bits without a start are ignored
        q0 = rxq.size();
        do_start();
        send_byte(ADDR_WR, 1'b1, "R3 address ack");
        do_stop();
        scl_m = 1'b0;
        wclk(HALF);
        send_byte(8'h77, 1'b0, "R11 standby after stop");
        chk(rxq.size() == q0, "R11 no byte in standby", 32'(rxq.size() - q0), 0);

        // Sequential read: R8, R9
        l0 = n_load; pp = rd_ptr; mackq.delete();
        do_start();
        send_byte(ADDR_RD, 1'b1, "R3 read address ack");
        chk(rd == 1'b1, "R3 read direction", 32'(rd), 1);
        recv_byte(mem[pp % 8], 1'b1, "R8 read byte 0");
        recv_byte(mem[(pp + 1) % 8], 1'b1, "R8 read byte 1");
        recv_byte(mem[(pp + 2) % 8], 1'b0, "R8 read byte 2");
        chk(n_load == l0 + 3, "R8 load pulses", 32'(n_load - l0), 3);
        chk(mackq.size() == 3 && mackq[0] && mackq[1] && !mackq[2], "R9 master ack sequence",
            32'(mackq.size()), 3);
        send_byte(8'hFF, 1'b0, "R9 silent until stop");
        chk(n_load == l0 + 3, "R9 no load after nack", 32'(n_load - l0), 3);
        do_stop();

        // R10: write the word address, repeated start, then read
        s0 = n_start; p0 = n_stop; pp = 0;
        do_start();
        send_byte(ADDR_WR, 1'b1, "R3 address ack");
        send_byte(8'h12, 1'b1, "R6 word address ack");
        pp = rd_ptr;
        do_start();
        chk(n_start == s0 + 2 && n_stop == p0, "R10 repeated start", 32'(n_start - s0), 2);
        send_byte(ADDR_RD, 1'b1, "R10 address ack after repeated start");
        recv_byte(mem[pp % 8], 1'b0, "R10 read after repeated start");
        do_stop();
        chk(rxq[rxq.size()-1] == 8'h12, "R2 word address byte", 32'(rxq[rxq.size()-1]), 32'h12);
        chk(sda_oe == 1'b0, "R11 released at end", 32'(sda_oe), 0);

        wclk(HALF);
        mon_en = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule